// File: doc/BRIEF.md
# TDM Output Slot Serializer

This block turns parallel audio samples into serial time-division-multiplexed data on up to four data lanes. The bit clock and frame sync are generated outside the block. They reach it as a one-cycle bit-period strobe and a frame-sync level, both sampled in the system clock domain. On each strobe every lane shifts out one bit. A frame starts on a rising edge of the frame sync, after optional polarity inversion. A programmable lead-in of bit periods comes next, and then a programmable number of slots follows, each of programmable width. Within a slot the sample goes out MSB first, starting from a programmable MSB position, so a narrow sample can sit inside a wider slot. The slot bits after the sample LSB are zero.

Each lane has one enable bit and one mute bit per slot. If no lane is enabled for a slot, that slot takes nothing from the sample input. An enabled lane carries its share of one input beat: lane `l` takes its bits from `s_data` starting at bit `32*l`. A muted lane still consumes the beat but sends the mute word instead. A disabled lane sends the fill word. If a beat is needed and none is offered, the enabled lanes send zero and a sticky underflow flag is raised.

Software brings the block up in a fixed order: it releases the output-side reset, then the input-side reset, then sets enable. After that the block waits for the next frame start before it drives any data.

Top module: `tdm_out_serializer`

## Requirements
- R1: While `rst_n` is low, `tdm_dout` is 0, `s_ready` is 0 and `underflow` is 0.
- R2: The lead-in is the skew `SKEW_BASE + cfg_fmt_late`, with `SKEW_BASE` defaulting to 1. Let T0 be the strobe at which the effective frame sync is first seen high after being low. The slot-0 MSB is driven from strobe T0+skew, and the lanes are 0 from T0 until then.
- R3: A slot lasts `cfg_slot_w_m1+1` strobes. Slot bit b (b=0 first) carries word bit `cfg_msb_pos-b` when b <= `cfg_msb_pos`, and 0 otherwise.
- R4: After the last bit of slot `cfg_slots_m1`, the lanes drive 0 until the next frame start.
- R5: With `cfg_ws_inv`=1, the frame sync is inverted before edge detection, so a falling edge of `fsync` starts the frame.
- R6: The enable bit for lane l, slot s is bit `32*l+s` of `cfg_slot_en`. A slot where that bit is 0 carries `cfg_fill_val` on that lane. A slot with no enabled lane takes no beat. A slot with at least one enabled lane takes exactly one beat.
- R7: The mute bit for lane l, slot s is bit `32*l+s` of `cfg_slot_mute`. An enabled, muted slot consumes its beat but carries `cfg_mute_val`.
- R8: If a slot needs a beat and `s_valid` is 0, the enabled lanes send zero and `underflow` rises. The flag stays set until `cfg_rst_in_n` is driven low.
- R9: The lanes are 0 and no beat is taken unless `cfg_enable`, `cfg_rst_out_n` and `cfg_rst_in_n` are all 1. Once running, the block waits for a frame start.
- R10: `s_ready` is high only in a strobe cycle at the start of a slot that needs a beat. It is high once per such slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_tick | input | 1 | One-cycle strobe marking a new bit period |
| fsync | input | 1 | Frame sync level, sampled on strobes |
| cfg_rst_out_n | input | 1 | Output-side reset, active low |
| cfg_rst_in_n | input | 1 | Input-side reset, active low; also clears underflow |
| cfg_enable | input | 1 | Run enable |
| cfg_ws_inv | input | 1 | Invert frame sync polarity |
| cfg_fmt_late | input | 1 | Add one bit period to the base skew |
| cfg_slot_w_m1 | input | 5 | Slot width minus one |
| cfg_slots_m1 | input | 5 | Slots per frame minus one |
| cfg_msb_pos | input | 5 | Sample width minus one (MSB position) |
| cfg_slot_en | input | 128 | Per-lane, per-slot enable mask |
| cfg_slot_mute | input | 128 | Per-lane, per-slot mute mask |
| cfg_mute_val | input | 32 | Word sent in muted slots |
| cfg_fill_val | input | 32 | Word sent in disabled slots |
| s_valid | input | 1 | Sample beat offered |
| s_data | input | 128 | One 32-bit sample per lane |
| s_ready | output | 1 | Beat taken this cycle |
| tdm_dout | output | 4 | Serial lane outputs |
| underflow | output | 1 | Sticky underflow flag |

## Verification
A lane bit is registered at the clock edge that ends a strobe cycle. The bench therefore reads `tdm_dout` on the falling edge that follows each strobe, and matches it against the bit that strobe should have launched. `s_ready` is combinational within the strobe cycle, so the bench reads it one nanosecond after driving that cycle's inputs. That same reading decides whether the beat is retired from the bench's queue. `underflow` is due one edge after the starved strobe, and the bench reads it only after the frame has ended. Every frame ends with idle strobes, which lets the number of beats left in the queue be compared with the count the model predicts.

// File: rtl/tdm_ser_pkg.sv
`timescale 1ns/1ps
package tdm_ser_pkg;
  localparam int CNT_W     = 5;
  localparam int SLOT_BITS = 2 ** CNT_W;
  localparam int MAX_SLOTS = 2 ** CNT_W;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LEAD = 2'd1,
    ST_SLOT = 2'd2
  } seq_st_e;

  // Position the lanes will present after the current strobe.
  typedef struct packed {
    logic             active;
    logic             start;
    logic [CNT_W-1:0] bidx;
    logic [CNT_W-1:0] slot;
  } tdm_pos_t;
endpackage

// File: rtl/tdm_frame_sync.sv
`timescale 1ns/1ps
module tdm_frame_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic fsync,
  input  logic ws_inv,
  output logic fstart
);
  logic fs_eff;
  logic fs_prev_q;
  logic fs_prev_d;

  always_comb begin
    fs_eff    = fsync ^ ws_inv;
    fstart    = tick & fs_eff & ~fs_prev_q;
    fs_prev_d = tick ? fs_eff : fs_prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fs_prev_q <= 1'b0;
    else        fs_prev_q <= fs_prev_d;
  end

  // R5
  edge_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fstart |=> !fstart);
endmodule

// File: rtl/tdm_slot_ctr.sv
`timescale 1ns/1ps
module tdm_slot_ctr
  import tdm_ser_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             fstart,
  input  logic [CNT_W-1:0] skew,
  input  logic [CNT_W-1:0] slot_w_m1,
  input  logic [CNT_W-1:0] slots_m1,
  output tdm_pos_t         pos_nxt
);
  seq_st_e          st_q, st_d;
  logic [CNT_W-1:0] lead_q, lead_d;
  logic [CNT_W-1:0] bidx_q, bidx_d;
  logic [CNT_W-1:0] slot_q, slot_d;
  logic             start_d;

  always_comb begin
    st_d    = st_q;
    lead_d  = lead_q;
    bidx_d  = bidx_q;
    slot_d  = slot_q;
    start_d = 1'b0;
    if (!run) begin
      st_d   = ST_IDLE;
      lead_d = '0;
      bidx_d = '0;
      slot_d = '0;
    end else if (tick) begin
      if (fstart) begin
        bidx_d = '0;
        slot_d = '0;
        if (skew == '0) begin
          st_d    = ST_SLOT;
          start_d = 1'b1;
        end else begin
          st_d   = ST_LEAD;
          lead_d = skew;
        end
      end else begin
        case (st_q)
          ST_LEAD: begin
            if (lead_q == CNT_W'(1)) begin
              st_d    = ST_SLOT;
              start_d = 1'b1;
              bidx_d  = '0;
              slot_d  = '0;
            end else begin
              lead_d = lead_q - CNT_W'(1);
            end
          end
          ST_SLOT: begin
            if (bidx_q >= slot_w_m1) begin
              bidx_d = '0;
              if (slot_q >= slots_m1) begin
                st_d = ST_IDLE;
              end else begin
                slot_d  = slot_q + CNT_W'(1);
                start_d = 1'b1;
              end
            end else begin
              bidx_d = bidx_q + CNT_W'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    pos_nxt.active = (st_d == ST_SLOT);
    pos_nxt.start  = start_d;
    pos_nxt.bidx   = bidx_d;
    pos_nxt.slot   = slot_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      lead_q <= '0;
      bidx_q <= '0;
      slot_q <= '0;
    end else begin
      st_q   <= st_d;
      lead_q <= lead_d;
      bidx_q <= bidx_d;
      slot_q <= slot_d;
    end
  end

  // R2
  frame_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && fstart) |=> (slot_q == '0 && bidx_q == '0 && st_q != ST_IDLE));

  // R3
  bit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !fstart && st_q == ST_SLOT && bidx_q < slot_w_m1)
      |=> (bidx_q == $past(bidx_q) + CNT_W'(1)));

  // R4
  frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !fstart && st_q == ST_SLOT && bidx_q >= slot_w_m1 && slot_q >= slots_m1)
      |=> (st_q == ST_IDLE));
endmodule

// File: rtl/tdm_lane_fmt.sv
`timescale 1ns/1ps
module tdm_lane_fmt
  import tdm_ser_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic                 tick,
  input  tdm_pos_t             pos,
  input  logic [CNT_W-1:0]     msb_pos,
  input  logic [MAX_SLOTS-1:0] en_row,
  input  logic [MAX_SLOTS-1:0] mute_row,
  input  logic [SLOT_BITS-1:0] sample,
  input  logic                 have_sample,
  input  logic [SLOT_BITS-1:0] mute_val,
  input  logic [SLOT_BITS-1:0] fill_val,
  output logic                 slot_used,
  output logic                 dout
);
  logic [SLOT_BITS-1:0] word_q, word_d, load_word, word_sel;
  logic [CNT_W-1:0]     sel_idx;
  logic                 dout_q, dout_d, load_en;

  always_comb begin
    slot_used = en_row[pos.slot];
    if (!slot_used)                load_word = fill_val;
    else if (!have_sample)         load_word = '0;
    else if (mute_row[pos.slot])   load_word = mute_val;
    else                           load_word = sample;
    load_en  = run & tick & pos.start;
    word_d   = load_en ? load_word : word_q;
    word_sel = pos.start ? load_word : word_q;
    sel_idx  = msb_pos - pos.bidx;
    if (!run)             dout_d = 1'b0;
    else if (!tick)       dout_d = dout_q;
    else if (pos.active && pos.bidx <= msb_pos) dout_d = word_sel[sel_idx];
    else                  dout_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      dout_q <= 1'b0;
    end else begin
      word_q <= word_d;
      dout_q <= dout_d;
    end
  end

  assign dout = dout_q;

  // R4
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !pos.active) |=> !dout);

  // R3
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && pos.active && pos.bidx > msb_pos) |=> !dout);
endmodule

// File: rtl/tdm_out_serializer.sv
`timescale 1ns/1ps
module tdm_out_serializer
  import tdm_ser_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int SKEW_BASE = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bclk_tick,
  input  logic                       fsync,
  input  logic                       cfg_rst_out_n,
  input  logic                       cfg_rst_in_n,
  input  logic                       cfg_enable,
  input  logic                       cfg_ws_inv,
  input  logic                       cfg_fmt_late,
  input  logic [CNT_W-1:0]           cfg_slot_w_m1,
  input  logic [CNT_W-1:0]           cfg_slots_m1,
  input  logic [CNT_W-1:0]           cfg_msb_pos,
  input  logic [LANES*MAX_SLOTS-1:0] cfg_slot_en,
  input  logic [LANES*MAX_SLOTS-1:0] cfg_slot_mute,
  input  logic [SLOT_BITS-1:0]       cfg_mute_val,
  input  logic [SLOT_BITS-1:0]       cfg_fill_val,
  input  logic                       s_valid,
  input  logic [LANES*SLOT_BITS-1:0] s_data,
  output logic                       s_ready,
  output logic [LANES-1:0]           tdm_dout,
  output logic                       underflow
);
  localparam logic [CNT_W-1:0] SKEW_B = CNT_W'(SKEW_BASE);

  logic             run;
  logic             fstart;
  logic [CNT_W-1:0] skew;
  tdm_pos_t         pos;
  logic [LANES-1:0] used_vec;
  logic             need, take;
  logic             uflow_q, uflow_d;

  always_comb begin
    run  = cfg_enable & cfg_rst_out_n & cfg_rst_in_n;
    skew = SKEW_B + CNT_W'(cfg_fmt_late);
  end

  tdm_frame_sync u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (bclk_tick),
    .fsync  (fsync),
    .ws_inv (cfg_ws_inv),
    .fstart (fstart)
  );

  tdm_slot_ctr u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .tick      (bclk_tick),
    .fstart    (fstart),
    .skew      (skew),
    .slot_w_m1 (cfg_slot_w_m1),
    .slots_m1  (cfg_slots_m1),
    .pos_nxt   (pos)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    tdm_lane_fmt u_fmt (
      .clk         (clk),
      .rst_n       (rst_n),
      .run         (run),
      .tick        (bclk_tick),
      .pos         (pos),
      .msb_pos     (cfg_msb_pos),
      .en_row      (cfg_slot_en[l*MAX_SLOTS +: MAX_SLOTS]),
      .mute_row    (cfg_slot_mute[l*MAX_SLOTS +: MAX_SLOTS]),
      .sample      (s_data[l*SLOT_BITS +: SLOT_BITS]),
      .have_sample (s_valid),
      .mute_val    (cfg_mute_val),
      .fill_val    (cfg_fill_val),
      .slot_used   (used_vec[l]),
      .dout        (tdm_dout[l])
    );
  end

  always_comb begin
    need    = |used_vec;
    take    = run & bclk_tick & pos.start & need;
    s_ready = take;
    if (!cfg_rst_in_n)         uflow_d = 1'b0;
    else if (take && !s_valid) uflow_d = 1'b1;
    else                       uflow_d = uflow_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) uflow_q <= 1'b0;
    else        uflow_q <= uflow_d;
  end

  assign underflow = uflow_q;

  // R9
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> (tdm_dout == '0));

  // R8
  uflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && cfg_rst_in_n) |=> underflow);

  // R10
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (bclk_tick && cfg_enable && cfg_rst_in_n && cfg_rst_out_n));
endmodule

// File: tb/tdm_out_serializer_bench.sv
`timescale 1ns/1ps
module tdm_out_serializer_bench;
  localparam int LN = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst_n, bclk_tick, fsync;
  logic         cfg_rst_out_n, cfg_rst_in_n, cfg_enable, cfg_ws_inv, cfg_fmt_late;
  logic [4:0]   cfg_slot_w_m1, cfg_slots_m1, cfg_msb_pos;
  logic [127:0] cfg_slot_en, cfg_slot_mute;
  logic [31:0]  cfg_mute_val, cfg_fill_val;
  logic         s_valid;
  logic [127:0] s_data;
  logic         s_ready;
  logic [3:0]   tdm_dout;
  logic         underflow;

  tdm_out_serializer u_tdm_out_serializer (
    .clk(clk), .rst_n(rst_n), .bclk_tick(bclk_tick), .fsync(fsync),
    .cfg_rst_out_n(cfg_rst_out_n), .cfg_rst_in_n(cfg_rst_in_n),
    .cfg_enable(cfg_enable), .cfg_ws_inv(cfg_ws_inv), .cfg_fmt_late(cfg_fmt_late),
    .cfg_slot_w_m1(cfg_slot_w_m1), .cfg_slots_m1(cfg_slots_m1), .cfg_msb_pos(cfg_msb_pos),
    .cfg_slot_en(cfg_slot_en), .cfg_slot_mute(cfg_slot_mute),
    .cfg_mute_val(cfg_mute_val), .cfg_fill_val(cfg_fill_val),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .tdm_dout(tdm_dout), .underflow(underflow)
  );

  logic [127:0] sq[$];
  logic [3:0]   exp_q[$];
  logic [3:0]   mon_e;
  string        phase;
  int           n_cmp = 0, n_bad = 0;
  int           bad_ready = 0, ready_cnt = 0, exp_ready = 0, gctr = 0;
  bit           take_pend = 0, launched = 0, done = 0;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic wbit(input logic [31:0] w, input int msb, input int b);
    return (b <= msb) ? w[msb-b] : 1'b0;
  endfunction

  // Driver: one bit period of four clocks; strobe in the first.
  task automatic step(input logic fs_v, input logic [3:0] ev);
    exp_q.push_back(ev);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      if (take_pend && sq.size() > 0) void'(sq.pop_front());
      bclk_tick = (c == 0);
      if (c == 0) fsync = fs_v;
      s_valid = (sq.size() > 0);
      s_data  = s_valid ? sq[0] : '0;
      #1;
      take_pend = s_valid && s_ready;
      if (s_ready) begin
        ready_cnt++;
        if (!bclk_tick) bad_ready++;
      end
      launched = bclk_tick;
    end
  endtask

  // Monitor: compares each launched lane bit with the scoreboard.
  always @(negedge clk) begin
    if (launched) begin
      if (exp_q.size() == 0) begin
        chk({phase, " no expectation"}, 1, 0);
      end else begin
        mon_e = exp_q.pop_front();
        chk(phase, 128'(tdm_dout), 128'(mon_e));
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(cfg_ws_inv, 4'h0);
  endtask

  task automatic run_frame(input int w, input int ns, input int msb, input bit late,
                           input int n_avail, input bit live);
    logic [127:0] smp[$];
    logic [31:0]  wd [32][4];
    logic [3:0]   ev;
    int si, skew, n, need, pos;
    cfg_slot_w_m1 = 5'(w - 1);
    cfg_slots_m1  = 5'(ns - 1);
    cfg_msb_pos   = 5'(msb);
    cfg_fmt_late  = late;
    for (int i = 0; i < n_avail; i++) begin
      logic [127:0] v;
      gctr++;
      for (int l = 0; l < LN; l++)
        v[l*32 +: 32] = 32'h1357_9BDF * gctr + 32'h0101_0101 * l + 32'hC001_0000;
      smp.push_back(v);
      sq.push_back(v);
    end
    si = 0;
    for (int s = 0; s < ns; s++) begin
      need = 0;
      for (int l = 0; l < LN; l++) if (cfg_slot_en[l*32+s]) need = 1;
      for (int l = 0; l < LN; l++) begin
        if (!cfg_slot_en[l*32+s])   wd[s][l] = cfg_fill_val;
        else if (si >= n_avail)     wd[s][l] = '0;
        else if (cfg_slot_mute[l*32+s]) wd[s][l] = cfg_mute_val;
        else                        wd[s][l] = smp[si][l*32 +: 32];
      end
      if (need != 0 && live) exp_ready++;
      if (need != 0 && si < n_avail) si++;
    end
    skew = 1 + int'(late);
    n = skew + ns * w + 2;
    for (int k = 0; k < n; k++) begin
      ev = '0;
      pos = k - skew;
      if (live && k >= skew && pos < ns * w)
        for (int l = 0; l < LN; l++) ev[l] = wbit(wd[pos / w][l], msb, pos % w);
      step(((k == 0) ? 1'b1 : 1'b0) ^ cfg_ws_inv, ev);
    end
    chk({phase, " beats left"}, 128'(sq.size()), live ? 128'(n_avail - si) : 128'(n_avail));
    sq.delete();
    take_pend = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired in phase %s", phase);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; bclk_tick = 0; fsync = 0; s_valid = 0; s_data = '0;
    cfg_rst_out_n = 0; cfg_rst_in_n = 0; cfg_enable = 0; cfg_ws_inv = 0; cfg_fmt_late = 0;
    cfg_slot_w_m1 = 5'd15; cfg_slots_m1 = 5'd3; cfg_msb_pos = 5'd15;
    cfg_slot_en = '1; cfg_slot_mute = '0;
    cfg_mute_val = 32'h5A5A_C3C3; cfg_fill_val = 32'hF0F0_1234;
    phase = "R1 reset";
    repeat (4) @(negedge clk);
    #1;
    chk("R1 dout", 128'(tdm_dout), 0);
    chk("R1 ready", 128'(s_ready), 0);
    chk("R1 underflow", 128'(underflow), 0);
    @(negedge clk);
    rst_n = 1;

    // R9: input side still held, nothing may run
    cfg_rst_out_n = 1; cfg_enable = 1;
    phase = "R9 input reset held";
    run_frame(16, 4, 15, 0, 4, 0);
    cfg_rst_in_n = 1;
    phase = "R9 wait for frame";
    idle(3);

    phase = "R3 frame base skew";
    run_frame(16, 4, 15, 0, 4, 1);
    phase = "R2 late skew";
    run_frame(16, 4, 15, 1, 4, 1);
    phase = "R4 single slot narrow sample";
    run_frame(8, 1, 3, 0, 1, 1);

    // R6 R7: mixed enables, a muted slot, a silent lane
    cfg_slot_en = '0;
    cfg_slot_en[0] = 1; cfg_slot_en[1] = 1; cfg_slot_en[33] = 1; cfg_slot_en[96] = 1;
    cfg_slot_mute = '0; cfg_slot_mute[96] = 1;
    phase = "R6 R7 masks and mute";
    run_frame(24, 2, 15, 1, 2, 1);

    // R5: inverted frame sync, middle slot unused by every lane
    cfg_slot_mute = '0;
    cfg_slot_en = {4{32'h0000_0005}};
    cfg_ws_inv = 1;
    phase = "R5 inverted sync";
    idle(2);
    run_frame(8, 3, 7, 0, 2, 1);
    cfg_ws_inv = 0;
    idle(2);

    // R8: only one beat for four slots
    cfg_slot_en = '1;
    phase = "R8 underflow";
    run_frame(16, 4, 15, 0, 1, 1);
    idle(2);
    #1;
    chk("R8 flag set and held", 128'(underflow), 1);
    cfg_rst_in_n = 0;
    @(negedge clk);
    @(negedge clk);
    #1;
    chk("R8 flag cleared by input reset", 128'(underflow), 0);
    cfg_rst_in_n = 1;

    cfg_enable = 0;
    phase = "R9 disabled";
    run_frame(16, 4, 15, 0, 4, 0);

    chk("R10 ready outside strobe", 128'(bad_ready), 0);
    chk("R10 ready pulses per needing slot", 128'(ready_cnt), 128'(exp_ready));

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule